// File: doc/BRIEF.md
# Multi-Size Logical Left Shift Execution Unit

This unit carries out a logical left shift on an operand that lives inside a 32-bit register image. It takes a 16-bit instruction word that picks the operand size (byte, word or long) and, for the immediate forms, the shift amount. A separate mode input switches to a count held in a byte register. The unit returns the updated register image and the five condition flags H, N, Z, V and C.

Only the slice that matches the operand size is rewritten. Bits above that slice come back exactly as they went in. Flags are computed at the operand size.

Results are registered. They appear one clock after a valid strobe, together with a one-cycle valid pulse. If the instruction word matches no known encoding, the unit raises an illegal-opcode output, returns the register image unchanged and keeps its previous flags.

Top module: `shl_unit`

## Requirements
- R1: A byte-size operation rewrites only bits 7:0 of the register image. Bits 31:8 are returned unchanged (0xA5A5A5A5 shifted as a byte by one gives 0xA5A5A54A).
- R2: A word-size operation rewrites only bits 15:0 of the register image. Bits 31:16 are returned unchanged (0xA5A5A5A5 shifted as a word by eight gives 0xA5A5A500).
- R3: Every legal operation clears H and V.
- R4: N is the most significant bit of the result slice. Z is set exactly when the result slice is all zeros, whatever the bits above the slice hold.
- R5: C is the last bit shifted out of the slice's most significant bit. C is 0 when the count is zero, and also when the count exceeds the operand width. A count of zero leaves the operand unchanged.
- R6: Byte encodings: the high byte is 0x10 and the upper nibble of the low byte selects the count, with 0x0 giving 1, 0x4 giving 2 and 0xA giving 4. The lowest nibble (the register number) has no effect on the result.
- R7: Word encodings: the high byte is 0x10 and the upper nibble of the low byte selects the count, with 0x1 giving 1, 0x5 giving 2, 0x2 giving 4 and 0x6 giving 8. The lowest nibble has no effect on the result.
- R8: Long encodings: the high byte is 0x10 and the low byte selects the count. Low bytes 0x30–0x37 give 1, 0x70–0x77 give 2, 0x38–0x3F give 4, 0x78–0x7F give 8 and 0xF8–0xFF give 16. Bits 2:0 (the register number) have no effect on the result.
- R9: When the count mode input is 1, the operand size still comes from a legal encoding, but the count is bits 4:0 of the count byte. The opcode's own count and bits 7:5 of the count byte are ignored (0xA5A5A5A5 shifted as a long by 5 gives 0xB4B4B4A0 with N=1 and C=0).
- R10: Any other instruction word raises the illegal output for that result. The returned image equals the input image and all five flags keep their previous values.
- R11: The result, flags and illegal output appear one clock after a valid input, with out_valid high for exactly that cycle. Synchronous active-high reset clears the flags, the result, illegal and out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| cnt_mode | input | 1 | 1: shift count from count byte |
| cnt_byte | input | 8 | Count register byte |
| opnd_i | input | 32 | Register image holding the operand |
| out_valid | output | 1 | Result valid pulse |
| res_o | output | 32 | Updated register image |
| flag_h | output | 1 | Half-carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| illegal | output | 1 | Unrecognised instruction word |

## Verification
The bench sweeps all 256 low bytes under the 0x10 prefix on several operands, and every other prefix byte. This catches a decoder that mistakes a word or long nibble for a byte one, or that accepts a long low byte in 0xF0–0xF7. Sweeping the register count through all 64 values of its low six bits, with the upper bits set, exposes a unit that uses bit 5 or clamps the count. The same sweep exposes a carry taken from the 32-bit boundary instead of the slice boundary, and a C left set after a zero count or a count beyond the width. Operands with a zero slice under non-zero upper bits catch a Z computed over the whole image. Illegal words placed right after legal ones show whether the flags are wrongly overwritten.

// File: rtl/shl_pkg.sv
package shl_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [7:0] PREFIX = 8'h10;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } opsz_e;

    typedef struct packed {
        logic             legal;
        opsz_e            size;
        logic [CNT_W-1:0] count;
    } dec_t;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic [DATA_W-1:0] size_mask(input opsz_e sz);
        logic [DATA_W-1:0] m;
        case (sz)
            SZ_BYTE: m = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            SZ_WORD: m = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
            SZ_LONG: m = {DATA_W{1'b1}};
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_of(input int n);
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/shl_decode.sv
module shl_decode
    import shl_pkg::*;
(
    input  logic [15:0] instr,
    input  logic        cnt_mode,
    input  logic [7:0]  cnt_byte,
    output dec_t        dec
);

    logic unused_fields;
    assign unused_fields = ^{instr[2:0], cnt_byte[7:CNT_W]};

    always_comb begin
        dec.legal = 1'b0;
        dec.size  = SZ_NONE;
        dec.count = '0;
        if (instr[15:8] == PREFIX) begin
            case (instr[7:4])
                4'h0: begin dec.legal = 1'b1; dec.size = SZ_BYTE; dec.count = cnt_of(1); end
                4'h4: begin dec.legal = 1'b1; dec.size = SZ_BYTE; dec.count = cnt_of(2); end
                4'hA: begin dec.legal = 1'b1; dec.size = SZ_BYTE; dec.count = cnt_of(4); end
                4'h1: begin dec.legal = 1'b1; dec.size = SZ_WORD; dec.count = cnt_of(1); end
                4'h5: begin dec.legal = 1'b1; dec.size = SZ_WORD; dec.count = cnt_of(2); end
                4'h2: begin dec.legal = 1'b1; dec.size = SZ_WORD; dec.count = cnt_of(4); end
                4'h6: begin dec.legal = 1'b1; dec.size = SZ_WORD; dec.count = cnt_of(8); end
                4'h3: begin
                    dec.legal = 1'b1;
                    dec.size  = SZ_LONG;
                    dec.count = instr[3] ? cnt_of(4) : cnt_of(1);
                end
                4'h7: begin
                    dec.legal = 1'b1;
                    dec.size  = SZ_LONG;
                    dec.count = instr[3] ? cnt_of(8) : cnt_of(2);
                end
                4'hF: begin
                    if (instr[3]) begin
                        dec.legal = 1'b1;
                        dec.size  = SZ_LONG;
                        dec.count = cnt_of(16);
                    end
                end
                default: ;
            endcase
            if (dec.legal && cnt_mode) begin
                dec.count = cnt_byte[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/shl_core.sv
module shl_core
    import shl_pkg::*;
(
    input  logic [DATA_W-1:0] opnd,
    input  opsz_e             size,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] result,
    output flags_t            flg
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] slice;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W:0]   wide;
    logic              carry;
    logic              msb;

    always_comb begin
        mask    = size_mask(size);
        slice   = opnd & mask;
        wide    = {1'b0, slice} << count;
        shifted = wide[DATA_W-1:0] & mask;
        case (size)
            SZ_BYTE: begin carry = wide[BYTE_W]; msb = shifted[BYTE_W-1]; end
            SZ_WORD: begin carry = wide[WORD_W]; msb = shifted[WORD_W-1]; end
            default: begin carry = wide[DATA_W]; msb = shifted[DATA_W-1]; end
        endcase
        result = (opnd & ~mask) | shifted;
        flg.h  = 1'b0;
        flg.v  = 1'b0;
        flg.n  = msb;
        flg.z  = (shifted == '0);
        flg.c  = carry;
    end

endmodule

// File: rtl/shl_unit.sv
module shl_unit
    import shl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] instr,
    input  logic        cnt_mode,
    input  logic [7:0]  cnt_byte,
    input  logic [31:0] opnd_i,
    output logic        out_valid,
    output logic [31:0] res_o,
    output logic        flag_h,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c,
    output logic        illegal
);

    dec_t              dec;
    logic [DATA_W-1:0] core_res;
    flags_t            core_flg;

    logic [DATA_W-1:0] res_q;
    flags_t            flags_q;
    logic              illegal_q;
    logic              valid_q;

    shl_decode u_decode (
        .instr    (instr),
        .cnt_mode (cnt_mode),
        .cnt_byte (cnt_byte),
        .dec      (dec)
    );

    shl_core u_core (
        .opnd   (opnd_i),
        .size   (dec.size),
        .count  (dec.count),
        .result (core_res),
        .flg    (core_flg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            res_q     <= '0;
            flags_q   <= '0;
        end else begin
            valid_q   <= in_valid;
            illegal_q <= in_valid & ~dec.legal;
            if (in_valid) begin
                if (dec.legal) begin
                    res_q   <= core_res;
                    flags_q <= core_flg;
                end else begin
                    res_q   <= opnd_i;
                end
            end
        end
    end

    assign out_valid = valid_q;
    assign res_o     = res_q;
    assign illegal   = illegal_q;
    assign flag_h    = flags_q.h;
    assign flag_n    = flags_q.n;
    assign flag_z    = flags_q.z;
    assign flag_v    = flags_q.v;
    assign flag_c    = flags_q.c;

endmodule

// File: rtl/shl_unit_chk.sv
module shl_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] instr,
    input logic        cnt_mode,
    input logic [31:0] opnd_i,
    input logic        out_valid,
    input logic [31:0] res_o,
    input logic        flag_h,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c,
    input logic        illegal
);

    AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:8] == 8'h10 && instr[7:4] == 4'h0 && !cnt_mode)
        |=> (res_o[31:8] == $past(opnd_i[31:8]))); // R1

    AST_WORD_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:8] == 8'h10 && instr[7:4] == 4'h6)
        |=> (res_o[31:16] == $past(opnd_i[31:16]))); // R2

    AST_HV_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal) |-> (!flag_h && !flag_v)); // R3

    AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal) |-> !(flag_n && flag_z)); // R4

    AST_ILLEGAL_PREFIX: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:8] != 8'h10)
        |=> (illegal && res_o == $past(opnd_i))); // R10

    AST_ILLEGAL_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal)
        |-> $stable({flag_h, flag_n, flag_z, flag_v, flag_c})); // R10

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R11

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !illegal)); // R11

endmodule

bind shl_unit shl_unit_chk i_shl_unit_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .cnt_mode  (cnt_mode),
    .opnd_i    (opnd_i),
    .out_valid (out_valid),
    .res_o     (res_o),
    .flag_h    (flag_h),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .illegal   (illegal)
);

// File: tb/test_shl_unit.sv
`timescale 1ns/1ps
module test_shl_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        cnt_mode = 1'b0;
    logic [7:0]  cnt_byte = '0;
    logic [31:0] opnd_i = '0;
    logic        out_valid;
    logic [31:0] res_o;
    logic        flag_h, flag_n, flag_z, flag_v, flag_c;
    logic        illegal;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [4:0] mflags = '0;   // model flags {h,n,z,v,c}

    always #2 clk = ~clk;

    shl_unit i_shl_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .cnt_mode(cnt_mode), .cnt_byte(cnt_byte), .opnd_i(opnd_i),
        .out_valid(out_valid), .res_o(res_o),
        .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .illegal(illegal)
    );

    function automatic logic [4:0] dut_flags();
        return {flag_h, flag_n, flag_z, flag_v, flag_c};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference decode written from the encoding tables in the requirements.
    task automatic ref_dec(input logic [15:0] ins, output bit ok,
                           output int w, output int n);
        logic [7:0] lo;
        lo = ins[7:0];
        ok = 0; w = 0; n = 0;
        if (ins[15:8] == 8'h10) begin
            if      (lo[7:4] == 4'h0) begin ok = 1; w = 8;  n = 1; end
            else if (lo[7:4] == 4'h4) begin ok = 1; w = 8;  n = 2; end
            else if (lo[7:4] == 4'hA) begin ok = 1; w = 8;  n = 4; end
            else if (lo[7:4] == 4'h1) begin ok = 1; w = 16; n = 1; end
            else if (lo[7:4] == 4'h5) begin ok = 1; w = 16; n = 2; end
            else if (lo[7:4] == 4'h2) begin ok = 1; w = 16; n = 4; end
            else if (lo[7:4] == 4'h6) begin ok = 1; w = 16; n = 8; end
            else if (lo >= 8'h30 && lo <= 8'h37) begin ok = 1; w = 32; n = 1; end
            else if (lo >= 8'h70 && lo <= 8'h77) begin ok = 1; w = 32; n = 2; end
            else if (lo >= 8'h38 && lo <= 8'h3F) begin ok = 1; w = 32; n = 4; end
            else if (lo >= 8'h78 && lo <= 8'h7F) begin ok = 1; w = 32; n = 8; end
            else if (lo >= 8'hF8)                begin ok = 1; w = 32; n = 16; end
        end
    endtask

    // Bit-serial reference: shift one place at a time, tracking the bit leaving.
    task automatic model(input logic [15:0] ins, input logic md, input logic [7:0] cb,
                         input logic [31:0] op, output logic [31:0] er,
                         output logic [4:0] ef, output logic ei, output string tag);
        bit ok; int w; int n;
        longint mask, v, c;
        ref_dec(ins, ok, w, n);
        if (!ok) begin
            er = op; ef = mflags; ei = 1'b1; tag = "R10";
        end else begin
            if (md) n = int'(cb) % 32;
            mask = (longint'(1) << w) - 1;
            v = longint'(op) & mask;
            c = 0;
            for (int i = 0; i < n; i++) begin
                c = (v >> (w - 1)) & 1;
                v = (v << 1) & mask;
            end
            er = 32'((longint'(op) & ~mask) | v);
            ef = {1'b0, 1'(((v >> (w - 1)) & 1) != 0), (v == 0), 1'b0, 1'(c != 0)};
            ei = 1'b0;
            mflags = ef;
            tag = md ? "R9" : (w == 8) ? "R6" : (w == 16) ? "R7" : "R8";
        end
    endtask

    task automatic do_op(input logic [15:0] ins, input logic md, input logic [7:0] cb,
                         input logic [31:0] op);
        logic [31:0] er; logic [4:0] ef; logic ei; string tag;
        model(ins, md, cb, op, er, ef, ei, tag);
        @(negedge clk);
        check("R11", "idle out_valid", {31'b0, out_valid}, 32'd0);
        instr = ins; cnt_mode = md; cnt_byte = cb; opnd_i = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "result", res_o, er);
        check(tag, "flags(R3,R4,R5)", {27'b0, dut_flags()}, {27'b0, ef});
        check(tag, "illegal", {31'b0, illegal}, {31'b0, ei});
        check("R11", "out_valid", {31'b0, out_valid}, 32'd1);
    endtask

    task automatic gold(input string tag, input logic [15:0] ins, input logic md,
                        input logic [7:0] cb, input logic [31:0] op,
                        input logic [31:0] er, input logic [4:0] ef);
        do_op(ins, md, cb, op);
        check(tag, "golden result", res_o, er);
        check(tag, "golden flags", {27'b0, dut_flags()}, {27'b0, ef});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [31:0] PAT = 32'hA5A5A5A5;

    initial begin
        logic [31:0] ops [5];
        logic [31:0] snap_res; logic [4:0] snap_flg;
        ops[0] = PAT; ops[1] = 32'h00000080; ops[2] = 32'h12345678;
        ops[3] = 32'hFFFFFFFF; ops[4] = 32'h00000000;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11", "reset result", res_o, 32'd0);
        check("R11", "reset flags", {27'b0, dut_flags()}, 32'd0);
        check("R11", "reset illegal", {31'b0, illegal}, 32'd0);
        check("R11", "reset out_valid", {31'b0, out_valid}, 32'd0);

        // Golden vectors, flags {h,n,z,v,c}
        gold("R1", 16'h1008, 0, 8'h00, PAT, 32'hA5A5A54A, 5'b00001);
        gold("R6", 16'h1048, 0, 8'h00, PAT, 32'hA5A5A594, 5'b01000);
        gold("R6", 16'h10A8, 0, 8'h00, PAT, 32'hA5A5A550, 5'b00000);
        gold("R2", 16'h1010, 0, 8'h00, PAT, 32'hA5A54B4A, 5'b00001);
        gold("R7", 16'h1060, 0, 8'h00, PAT, 32'hA5A5A500, 5'b01001);
        gold("R7", 16'h1020, 0, 8'h00, PAT, 32'hA5A55A50, 5'b00000);
        gold("R8", 16'h1030, 0, 8'h00, PAT, 32'h4B4B4B4A, 5'b00001);
        gold("R8", 16'h1070, 0, 8'h00, PAT, 32'h96969694, 5'b01000);
        gold("R8", 16'h1078, 0, 8'h00, PAT, 32'hA5A5A500, 5'b01001);
        gold("R8", 16'h10F8, 0, 8'h00, PAT, 32'hA5A50000, 5'b01001);
        gold("R9", 16'h1030, 1, 8'h05, PAT, 32'hB4B4B4A0, 5'b01000);
        gold("R9", 16'h1030, 1, 8'hE5, PAT, 32'hB4B4B4A0, 5'b01000);
        gold("R9", 16'h1008, 1, 8'h05, PAT, 32'hA5A5A5A0, 5'b01000);
        gold("R5", 16'h1008, 1, 8'h00, PAT, PAT, 5'b01000);
        gold("R5", 16'h1008, 1, 8'h09, 32'h123456FF, 32'h12345600, 5'b00100);
        gold("R5", 16'h1008, 1, 8'h08, 32'h12345601, 32'h12345600, 5'b00101);
        gold("R4", 16'h1008, 0, 8'h00, 32'h12345680, 32'h12345600, 5'b00101);
        gold("R3", 16'h1010, 0, 8'h00, 32'h0000C000, 32'h00008000, 5'b01001);

        // R10: illegal words keep flags from the preceding legal result
        do_op(16'h1030, 0, 8'h00, PAT);
        snap_res = res_o; snap_flg = dut_flags();
        do_op(16'h1090, 0, 8'h00, 32'h0BADF00D);
        check("R10", "illegal returns input", res_o, 32'h0BADF00D);
        check("R10", "illegal keeps flags", {27'b0, dut_flags()}, {27'b0, snap_flg});
        check("R10", "illegal raised", {31'b0, illegal}, 32'd1);
        do_op(16'h10F3, 1, 8'h03, 32'h00000001);
        check("R10", "F0-F7 illegal", {31'b0, illegal}, 32'd1);
        check("R10", "flags still held", {27'b0, dut_flags()}, {27'b0, snap_flg});
        check("R8", "previous result was long shift", snap_res, 32'h4B4B4B4A);

        // Full sweep of low byte under the prefix, immediate counts (R6, R7, R8, R10)
        foreach (ops[k]) begin
            for (int b = 0; b < 256; b++) begin
                do_op({8'h10, 8'(b)}, 0, 8'h00, ops[k]);
            end
        end

        // Every other prefix byte is illegal (R10)
        for (int p = 0; p < 256; p++) begin
            if (p != 16) do_op({8'(p), 8'h08}, 0, 8'h00, 32'h5A5A5A5A);
        end

        // Register counts over 0..63 with upper bits set (R9, R5)
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 64; c++) begin
                logic [15:0] ins;
                ins = (s == 0) ? 16'h10A3 : (s == 1) ? 16'h1065 : 16'h10F9;
                do_op(ins, 1, 8'(c) | 8'hC0, PAT);
                do_op(ins, 1, 8'(c), 32'h80000181);
            end
        end

        @(negedge clk);
        check("R11", "final idle", {31'b0, out_valid}, 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule